// File: doc/BRIEF.md
# Four-Port Memory Crossbar

This block joins four 128-bit requester buses to four independent memory banks through a full crossbar. Each cycle every bus may present one request: an address, an access size, a write flag, write data and a valid strobe. The two high address bits pick the bank and the remaining bits pick the 128-bit line and the lanes within it. Requests aimed at different banks all go through in the same cycle, so up to four transfers complete together. A typical use is a core whose instruction fetch and two data accesses land on three separate banks while an I/O engine uses the fourth.

Banks are not tied to a kind of traffic: any bank holds instructions, data or both, and any bus reaches any bank. When several buses aim at one bank in the same cycle, a per-bank round-robin arbiter accepts one of them and holds the rest with ready low. A refused requester keeps its request up, or may withdraw it. Accesses are 32, 64 or 128 bits wide and naturally aligned. Narrow data sits in its own lanes of the 128-bit bus, a narrow write changes only those lanes, and read data comes back one cycle after acceptance.

Top module: `mem_xbar4`

## Requirements
- R1: Address bits [13:12] select the bank, bits [11:4] select the 128-bit line in that bank, and bits [3:2] select the 32-bit lane; any bus can write and read any bank.
- R2: Requests from different buses that target different banks are all accepted (ready high) in the same cycle, including one read fetch plus two data accesses on three separate banks.
- R3: A read accepted in cycle t gives rsp_valid high with its data in cycle t+1; rsp_valid is low in every other cycle.
- R4: Size code 2'b00 is a 32-bit access in lane addr[3:2], bits [32*lane+31:32*lane]; a write of this size changes only that lane of the line.
- R5: Size code 2'b01 is a 64-bit access in the half chosen by addr[3] (bits [127:64] when 1, [63:0] when 0); a write changes only that half.
- R6: Size codes 2'b10 and 2'b11 are both full 128-bit line accesses.
- R7: Read data lanes outside the access are zero, and rsp_rdata is all zero while rsp_valid is low.
- R8: Address bits below the access size are ignored: addr[1:0] always, addr[2] for 64-bit and addr[3:2] for 128-bit accesses.
- R9: At most one request per bank is accepted each cycle; a refused request has ready low and leaves the bank unchanged.
- R10: Each bank grants in round-robin order: the next grant goes to the first requesting bus after the last granted one, counting upward and wrapping; after reset bus 0 is first.
- R11: After reset, with no requests, every ready and rsp_valid is low.
- R12: req_ready is never high on a bus whose req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 4 | Request strobe per bus |
| req_addr | input | 4 x 14 | Byte address per bus |
| req_size | input | 4 x 2 | Access size per bus (00: 32, 01: 64, 10/11: 128 bits) |
| req_we | input | 4 | Write flag per bus |
| req_wdata | input | 4 x 128 | Write data per bus, narrow data in its own lanes |
| req_ready | output | 4 | Request accepted this cycle |
| rsp_valid | output | 4 | Read data valid |
| rsp_rdata | output | 4 x 128 | Read data, unused lanes zero |

## Verification
The two functions that share a cycle are parallel transfers to separate banks and arbitration of a collision on one bank. The bench drives all four buses in one cycle, first with four distinct banks, then with three buses on three banks, then with several buses on one bank. It judges the ready pattern in that cycle against the round-robin order, and it judges the read-back line contents against a bench-side model of each accepted, lane-masked write. A refused write that is withdrawn must leave its line intact.

// File: rtl/xbar_pkg.sv
// Shared constants and helpers for the four-port memory crossbar.
// Assumes a 128-bit line made of four 32-bit lanes.
package xbar_pkg;
    localparam int LINE_W   = 128;
    localparam int LANE_W   = 32;
    localparam int NLANE    = LINE_W / LANE_W;
    localparam int OFFS_W   = 4;   // byte offset bits within a line

    localparam logic [1:0] SZ_32  = 2'b00;
    localparam logic [1:0] SZ_64  = 2'b01;

    // Lane enables for an access of the given size at lane index lo.
    function automatic logic [NLANE-1:0] lane_sel(input logic [1:0] sz, input logic [1:0] lo);
        logic [NLANE-1:0] m;
        case (sz)
            SZ_32:   m = NLANE'(1) << lo;
            SZ_64:   m = lo[1] ? 4'b1100 : 4'b0011;
            default: m = '1;
        endcase
        return m;
    endfunction

    // Expand lane enables to a bit mask over the line.
    function automatic logic [LINE_W-1:0] lane_bits(input logic [NLANE-1:0] m);
        logic [LINE_W-1:0] b;
        for (int i = 0; i < NLANE; i++) begin
            b[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
        end
        return b;
    endfunction
endpackage

// File: rtl/xbar_rr_arb.sv
// Round-robin arbiter for one memory bank.
// Grants at most one requester per cycle, searching upward from the bus
// after the last winner. Grant is combinational; pointer updates on grant.
module xbar_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr;
    logic          found;
    int            widx;

    // Pick the first requester at or after the pointer, wrapping.
    always_comb begin
        int k;
        gnt   = '0;
        found = 1'b0;
        widx  = 0;
        for (int i = 0; i < N; i++) begin
            k = (int'(ptr) + i) % N;
            if (!found && req[k]) begin
                gnt[k] = 1'b1;
                found  = 1'b1;
                widx   = k;
            end
        end
    end

    // Move the pointer past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (found) begin
            ptr <= PW'((widx + 1) % N);
        end
    end
endmodule

// File: rtl/xbar_bank.sv
// Behavioural memory bank of 128-bit lines with per-lane write enables.
// One access per cycle; read data is registered and valid the next cycle.
// Contents are not reset.
module xbar_bank #(
    parameter int LINE_AW = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic                        we,
    input  logic [LINE_AW-1:0]          line,
    input  logic [xbar_pkg::NLANE-1:0]  lanes,
    input  logic [xbar_pkg::LINE_W-1:0] wdata,
    output logic [xbar_pkg::LINE_W-1:0] rdata
);
    import xbar_pkg::*;
    localparam int DEPTH = 1 << LINE_AW;

    logic [LINE_W-1:0] mem [DEPTH];

    // Lane-masked write.
    always_ff @(posedge clk) begin
        for (int l = 0; l < NLANE; l++) begin
            if (en && we && lanes[l]) begin
                mem[line][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    // Registered line read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= mem[line];
        end
    end
endmodule

// File: rtl/xbar_port.sv
// Per-bus request decode and response path.
// Splits the address into bank, line and lanes, remembers an accepted read
// for one cycle and returns the lane-masked line from the chosen bank.
module xbar_port #(
    parameter int ADDR_W = 14,
    parameter int NBLK   = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  valid,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [1:0]                            size,
    input  logic                                  we,
    input  logic                                  ready,
    input  logic [NBLK-1:0][xbar_pkg::LINE_W-1:0] bank_rd,
    output logic [$clog2(NBLK)-1:0]               blk,
    output logic [ADDR_W-$clog2(NBLK)-xbar_pkg::OFFS_W-1:0] line,
    output logic [xbar_pkg::NLANE-1:0]            lanes,
    output logic                                  rsp_valid,
    output logic [xbar_pkg::LINE_W-1:0]           rsp_rdata
);
    import xbar_pkg::*;
    localparam int BLK_W = $clog2(NBLK);

    logic [BLK_W-1:0] blk_q;
    logic [NLANE-1:0] lanes_q;

    // Address decode.
    always_comb begin
        blk   = addr[ADDR_W-1 -: BLK_W];
        line  = addr[ADDR_W-BLK_W-1 : OFFS_W];
        lanes = lane_sel(size, addr[3:2]);
    end

    // Remember an accepted read for its response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            blk_q     <= '0;
            lanes_q   <= '0;
        end else begin
            rsp_valid <= valid && ready && !we;
            blk_q     <= blk;
            lanes_q   <= lanes;
        end
    end

    // Return only the accessed lanes of the bank line.
    always_comb begin
        rsp_rdata = rsp_valid ? (bank_rd[blk_q] & lane_bits(lanes_q)) : '0;
    end
endmodule

// File: rtl/mem_xbar4.sv
// Full crossbar between NPORT 128-bit requester buses and NBLK memory banks.
// Each bank has its own round-robin arbiter; accepted requests are steered
// to the bank, read data returns one cycle later on the requesting bus.
// Assumes requesters hold a refused request or withdraw it.
module mem_xbar4 #(
    parameter int NPORT  = 4,
    parameter int NBLK   = 4,
    parameter int ADDR_W = 14
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NPORT-1:0]                       req_valid,
    input  logic [NPORT-1:0][ADDR_W-1:0]           req_addr,
    input  logic [NPORT-1:0][1:0]                  req_size,
    input  logic [NPORT-1:0]                       req_we,
    input  logic [NPORT-1:0][xbar_pkg::LINE_W-1:0] req_wdata,
    output logic [NPORT-1:0]                       req_ready,
    output logic [NPORT-1:0]                       rsp_valid,
    output logic [NPORT-1:0][xbar_pkg::LINE_W-1:0] rsp_rdata
);
    import xbar_pkg::*;
    localparam int BLK_W   = $clog2(NBLK);
    localparam int LINE_AW = ADDR_W - BLK_W - OFFS_W;

    logic [NPORT-1:0][BLK_W-1:0]   p_blk;
    logic [NPORT-1:0][LINE_AW-1:0] p_line;
    logic [NPORT-1:0][NLANE-1:0]   p_lanes;
    logic [NBLK-1:0][NPORT-1:0]    req_m;
    logic [NBLK-1:0][NPORT-1:0]    gnt_m;
    logic [NPORT-1:0][NBLK-1:0]    gnt_t;
    logic [NBLK-1:0][LINE_W-1:0]   bank_rd;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        xbar_port #(.ADDR_W(ADDR_W), .NBLK(NBLK)) port_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid    (req_valid[p]),
            .addr     (req_addr[p]),
            .size     (req_size[p]),
            .we       (req_we[p]),
            .ready    (req_ready[p]),
            .bank_rd  (bank_rd),
            .blk      (p_blk[p]),
            .line     (p_line[p]),
            .lanes    (p_lanes[p]),
            .rsp_valid(rsp_valid[p]),
            .rsp_rdata(rsp_rdata[p])
        );
        for (genvar b = 0; b < NBLK; b++) begin : g_x
            assign req_m[b][p] = req_valid[p] && (p_blk[p] == BLK_W'(b));
            assign gnt_t[p][b] = gnt_m[b][p];
        end
        assign req_ready[p] = |gnt_t[p];
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic               en;
        logic               we;
        logic [LINE_AW-1:0] line;
        logic [NLANE-1:0]   lanes;
        logic [LINE_W-1:0]  wdata;

        xbar_rr_arb #(.N(NPORT)) arb_i (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (req_m[b]),
            .gnt  (gnt_m[b])
        );

        // Steer the granted request onto this bank.
        always_comb begin
            en    = 1'b0;
            we    = 1'b0;
            line  = '0;
            lanes = '0;
            wdata = '0;
            for (int p = 0; p < NPORT; p++) begin
                if (gnt_m[b][p]) begin
                    en    = 1'b1;
                    we    = req_we[p];
                    line  = p_line[p];
                    lanes = p_lanes[p];
                    wdata = req_wdata[p];
                end
            end
        end

        xbar_bank #(.LINE_AW(LINE_AW)) bank_i (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (en),
            .we   (we),
            .line (line),
            .lanes(lanes),
            .wdata(wdata),
            .rdata(bank_rd[b])
        );
    end
endmodule

// File: rtl/xbar_chk.sv
// Protocol checker for the crossbar, bound to every instance of the top.
// Decodes bank numbers from the address on its own.
module xbar_chk #(
    parameter int NPORT  = 4,
    parameter int NBLK   = 4,
    parameter int ADDR_W = 14
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NPORT-1:0]             req_valid,
    input logic [NPORT-1:0][ADDR_W-1:0] req_addr,
    input logic [NPORT-1:0]             req_we,
    input logic [NPORT-1:0]             req_ready,
    input logic [NPORT-1:0]             rsp_valid,
    input logic [NPORT-1:0][127:0]      rsp_rdata
);
    localparam int BLK_W = $clog2(NBLK);

    logic [NBLK-1:0][NPORT-1:0] hit;
    logic                       clash;

    // Which valid buses aim at each bank, and whether any two share one.
    always_comb begin
        clash = 1'b0;
        for (int b = 0; b < NBLK; b++) begin
            for (int p = 0; p < NPORT; p++) begin
                hit[b][p] = req_valid[p] && (req_addr[p][ADDR_W-1 -: BLK_W] == BLK_W'(b));
            end
            if ($countones(hit[b]) > 1) clash = 1'b1;
        end
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_b
        // R9
        one_grant_per_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit[b] & req_ready) <= 1);
    end

    // R2
    disjoint_all_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clash |-> (req_ready == req_valid));

    for (genvar p = 0; p < NPORT; p++) begin : g_p
        // R12
        no_idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[p] |-> !req_ready[p]);
        // R3
        read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_ready[p] && !req_we[p]) |=> rsp_valid[p]);
        // R3
        no_stray_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_valid[p] && req_ready[p] && !req_we[p]) |=> !rsp_valid[p]);
        // R7
        quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rsp_valid[p] |-> (rsp_rdata[p] == '0));
    end
endmodule

bind mem_xbar4 xbar_chk #(.NPORT(NPORT), .NBLK(NBLK), .ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_we   (req_we),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
);

// File: tb/mem_xbar4_tb_top.sv
// Directed bench for the four-port memory crossbar.
module mem_xbar4_tb_top;
    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [3:0]            req_valid;
    logic [3:0][13:0]      req_addr;
    logic [3:0][1:0]       req_size;
    logic [3:0]            req_we;
    logic [3:0][127:0]     req_wdata;
    logic [3:0]            req_ready;
    logic [3:0]            rsp_valid;
    logic [3:0][127:0]     rsp_rdata;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    logic [127:0] shadow [4][256];

    always #4 clk = ~clk;

    mem_xbar4 dut_i (.*);

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] bmask(input logic [1:0] sz, input logic [3:0] lo);
        logic [127:0] m;
        case (sz)
            2'b00:   m = {96'b0, 32'hFFFF_FFFF} << (32 * lo[3:2]);
            2'b01:   m = lo[3] ? {64'hFFFF_FFFF_FFFF_FFFF, 64'b0} : {64'b0, 64'hFFFF_FFFF_FFFF_FFFF};
            default: m = '1;
        endcase
        return m;
    endfunction

    task automatic idle_all();
        req_valid = '0; req_addr = '0; req_size = '0; req_we = '0; req_wdata = '0;
    endtask

    task automatic put(input int p, input int blk, input int line, input logic [3:0] lo,
                       input logic [1:0] sz, input bit we, input logic [127:0] d);
        req_valid[p] = 1'b1;
        req_addr[p]  = {blk[1:0], line[7:0], lo};
        req_size[p]  = sz;
        req_we[p]    = we;
        req_wdata[p] = d;
    endtask

    // Record a write that the bench expects to be accepted.
    task automatic model_wr(input int blk, input int line, input logic [3:0] lo,
                            input logic [1:0] sz, input logic [127:0] d);
        logic [127:0] m;
        m = bmask(sz, lo);
        shadow[blk][line] = (shadow[blk][line] & ~m) | (d & m);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic look();
        #1;
    endtask

    // Single read on bus p, checked one cycle after acceptance.
    task automatic read_chk(input int p, input int blk, input int line, input logic [3:0] lo,
                            input logic [1:0] sz, input string req);
        logic [127:0] e;
        idle_all();
        put(p, blk, line, lo, sz, 1'b0, '0);
        look();
        check(req_ready[p] === 1'b1, req, {127'b0, req_ready[p]}, 128'd1);
        step();
        idle_all();
        look();
        e = shadow[blk][line] & bmask(sz, lo);
        check(rsp_valid[p] === 1'b1 && rsp_rdata[p] === e, req, rsp_rdata[p], e);
    endtask

    task automatic wr_one(input int p, input int blk, input int line, input logic [3:0] lo,
                          input logic [1:0] sz, input logic [127:0] d);
        idle_all();
        put(p, blk, line, lo, sz, 1'b1, d);
        model_wr(blk, line, lo, sz, d);
        step();
        idle_all();
    endtask

    task automatic t_reset();
        idle_all();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        look();
        // R11
        check(req_ready === 4'b0 && rsp_valid === 4'b0, "R11", {120'b0, req_ready, rsp_valid}, '0);
        // R7 data quiet while idle
        check(rsp_rdata === '0, "R7", rsp_rdata[0], '0);
    endtask

    task automatic t_parallel_full();
        logic [127:0] e;
        idle_all();
        for (int p = 0; p < 4; p++) begin
            put(p, p, 5 + p, 4'h0, (p == 3) ? 2'b11 : 2'b10, 1'b1, {4{32'hA000_0000 + 32'(p)}} ^ 128'(p * 77));
            model_wr(p, 5 + p, 4'h0, 2'b10, {4{32'hA000_0000 + 32'(p)}} ^ 128'(p * 77));
        end
        look();
        // R2 four distinct banks
        check(req_ready === 4'hF, "R2", {124'b0, req_ready}, 128'hF);
        step();
        idle_all();
        for (int p = 0; p < 4; p++) begin
            put(p, (p + 3) % 4, 5 + (p + 3) % 4, 4'h7, 2'b10, 1'b0, '0);
        end
        look();
        check(req_ready === 4'hF, "R2", {124'b0, req_ready}, 128'hF);
        step();
        idle_all();
        look();
        for (int p = 0; p < 4; p++) begin
            e = shadow[(p + 3) % 4][5 + (p + 3) % 4];
            // R1 cross-bank routing, R6 size 11 is full line, R3 timing, R8 low bits ignored
            check(rsp_valid[p] === 1'b1 && rsp_rdata[p] === e, "R1/R6", rsp_rdata[p], e);
        end
        step();
        look();
        // R3 no response without a read
        check(rsp_valid === 4'b0, "R3", {124'b0, rsp_valid}, '0);
    endtask

    task automatic t_fetch_two_data();
        logic [127:0] e;
        idle_all();
        put(0, 2, 6, 4'h0, 2'b10, 1'b0, '0);
        put(1, 0, 9, 4'h0, 2'b10, 1'b1, 128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6978);
        model_wr(0, 9, 4'h0, 2'b10, 128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6978);
        put(3, 1, 6, 4'h0, 2'b10, 1'b0, '0);
        look();
        // R2 fetch plus two data on three banks
        check(req_ready === 4'b1011, "R2", {124'b0, req_ready}, 128'hB);
        step();
        idle_all();
        look();
        e = shadow[2][6];
        check(rsp_valid === 4'b1001 && rsp_rdata[0] === e, "R3", rsp_rdata[0], e);
        e = shadow[1][6];
        check(rsp_rdata[3] === e, "R2", rsp_rdata[3], e);
        read_chk(2, 0, 9, 4'h0, 2'b10, "R1");
    endtask

    task automatic t_narrow32();
        wr_one(1, 1, 20, 4'h0, 2'b10, 128'h0000_1111_2222_3333_4444_5555_6666_7777);
        // R4 lane 2 write with stray low bits (R8)
        wr_one(1, 1, 20, 4'hB, 2'b00, 128'hDEAD_BEEF_CAFE_F00D_8765_4321_0BAD_F00D);
        read_chk(0, 1, 20, 4'h0, 2'b10, "R4");
        read_chk(2, 1, 20, 4'h8, 2'b00, "R7");
        read_chk(3, 1, 20, 4'h1, 2'b00, "R8");
    endtask

    task automatic t_narrow64();
        wr_one(2, 3, 21, 4'h0, 2'b10, 128'hFFFF_EEEE_DDDD_CCCC_BBBB_AAAA_9999_8888);
        wr_one(2, 3, 21, 4'hC, 2'b01, 128'h0102_0304_0506_0708_1112_1314_1516_1718);
        read_chk(1, 3, 21, 4'h0, 2'b10, "R5");
        read_chk(0, 3, 21, 4'h4, 2'b01, "R5");
        read_chk(0, 3, 21, 4'hE, 2'b01, "R8");
    endtask

    task automatic t_conflict_hold();
        // prime bank 2 so bus 0 is first in line
        wr_one(3, 2, 31, 4'h0, 2'b10, 128'h5A5A_5A5A_5A5A_5A5A_5A5A_5A5A_5A5A_5A5A);
        idle_all();
        put(0, 2, 30, 4'h0, 2'b10, 1'b1, 128'h1);
        put(1, 2, 31, 4'h0, 2'b10, 1'b1, 128'h2);
        model_wr(2, 30, 4'h0, 2'b10, 128'h1);
        look();
        // R9 one winner
        check(req_ready === 4'b0001, "R9", {124'b0, req_ready}, 128'h1);
        step();
        idle_all();
        // R9 withdrawn refused write left line intact
        read_chk(2, 2, 31, 4'h0, 2'b10, "R9");
        read_chk(2, 2, 30, 4'h0, 2'b10, "R9");
    endtask

    task automatic t_round_robin();
        logic [3:0] pend;
        // prime bank 3 so bus 0 is first in line
        wr_one(3, 3, 50, 4'h0, 2'b10, 128'h0);
        pend = 4'hF;
        for (int c = 0; c < 4; c++) begin
            idle_all();
            for (int p = 0; p < 4; p++)
                if (pend[p]) put(p, 3, 40 + p, 4'h0, 2'b10, 1'b1, 128'(1000 + p));
            model_wr(3, 40 + c, 4'h0, 2'b10, 128'(1000 + c));
            look();
            // R10 rotation 0,1,2,3
            check(req_ready === 4'(1 << c), "R10", {124'b0, req_ready}, 128'(1 << c));
            pend[c] = 1'b0;
            step();
        end
        // bus 1 alone, then buses 0 and 3: bus 3 follows bus 1
        wr_one(1, 3, 44, 4'h0, 2'b10, 128'h44);
        idle_all();
        put(0, 3, 45, 4'h0, 2'b10, 1'b1, 128'h45);
        put(3, 3, 46, 4'h0, 2'b10, 1'b1, 128'h46);
        look();
        check(req_ready === 4'b1000, "R10", {124'b0, req_ready}, 128'h8);
        step();
        model_wr(3, 46, 4'h0, 2'b10, 128'h46);
        req_valid[3] = 1'b0;
        look();
        check(req_ready === 4'b0001, "R10", {124'b0, req_ready}, 128'h1);
        model_wr(3, 45, 4'h0, 2'b10, 128'h45);
        step();
        idle_all();
        read_chk(2, 3, 42, 4'h0, 2'b10, "R10");
        read_chk(2, 3, 46, 4'h0, 2'b10, "R10");
        // R12 idle buses never ready
        look();
        check(req_ready === 4'b0, "R12", {124'b0, req_ready}, '0);
    endtask

    initial begin
        idle_all();
        t_reset();
        t_parallel_full();
        t_fetch_two_data();
        t_narrow32();
        t_narrow64();
        t_conflict_hold();
        t_round_robin();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule